// File: doc/BRIEF.md
# Resonant Half-Bridge Soft-Start Frequency Sequencer

This block produces the frequency command for a resonant half-bridge while it starts up, before the closed-loop oscillator takes control. Once the bus-sense comparator reports that the bus has reached three quarters of its reference, the command sweeps downward through three timed segments. It goes from a capped start frequency to an intermediate frequency, then to the maximum operating frequency, and finally to the minimum operating frequency. Each segment has its own length and slope, and the value inside a segment is interpolated linearly with an exact remainder accumulator.

Alongside the frequency, the block outputs a clamp code for the burst-control pin reference. The clamp stays at its low level in the first two segments and ramps to its high level across the third. A current-sense over-threshold flag freezes the sweep and its timers. In the third segment a feedback-balance flag hands control over early. If the sweep reaches the minimum frequency without a balance, it hands over at that frequency. Frequencies are unsigned codes in kHz. The clamp is a code in units of 10 mV, with defaults of 75 (0.75 V) and 225 (2.25 V).

Top module: `hb_softstart_seq`

## Requirements
- R1: After reset, and whenever idle, `phase_o` is 0, `freq_o` is 0, `clamp_o` is CL_LO (75), and `handover_o` is low.
- R2: In idle, a high `bus_ok_i` at a clock edge enters phase code 1 at that edge. The first command is min(`f_start_i`, FCAP), with FCAP = 1300.
- R3: Phase 1 lasts PH1_LEN advancing cycles. After t of them, `freq_o` = S - floor((S-M)*t/PH1_LEN). The next advancing cycle after the last one enters phase 2 at M.
- R4: Phase 2 moves from M to X in the same way over PH2_LEN advancing cycles, then enters phase 3 at X.
- R5: Phase 3 moves from X to N over PH3_LEN advancing cycles. In that phase `clamp_o` = CL_LO + floor((CL_HI-CL_LO)*t/PH3_LEN). In idle and in phases 1 and 2, `clamp_o` equals CL_LO.
- R6: A cycle with `cs_over_i` high is not an advancing cycle. Frequency, clamp and segment timers hold their values.
- R7: In phase 3, a high `fb_bal_i` enters phase code 4 at the next edge and pulses `handover_o` for one cycle. The frequency and clamp of the cycle before are then held. In phases 1 and 2, `fb_bal_i` is ignored.
- R8: When phase 3 completes without a balance, the block enters phase code 4 and pulses `handover_o` once. It then holds `freq_o` = N and `clamp_o` = CL_HI (225).
- R9: A low `bus_ok_i` in any phase returns the block to idle at the next edge, without a handover pulse.
- R10: The endpoints are captured at the start edge as follows: S = min(start, FCAP), M = min(mid, S), X = min(max, M), N = min(min, X). Later changes to the frequency inputs have no effect until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ok_i | input | 1 | Bus sense at or above 75 % of reference |
| cs_over_i | input | 1 | Low-side current sense above its freeze threshold |
| fb_bal_i | input | 1 | Feedback balanced (zero net burst-pin current) |
| f_start_i | input | FW | Start frequency code (kHz) |
| f_mid_i | input | FW | End-of-phase-1 frequency code |
| f_max_i | input | FW | Maximum operating frequency code |
| f_min_i | input | FW | Minimum operating frequency code |
| freq_o | output | FW | Frequency command |
| clamp_o | output | CW | Burst-pin reference clamp code |
| phase_o | output | 3 | 0 idle, 1 to 3 sweep phases, 4 handed over |
| handover_o | output | 1 | One-cycle handover pulse |

## Verification
On every cycle, the assertions check the following properties:
- The idle outputs and the cap on the start frequency.
- That the command never rises within a phase.
- That the clamp stays low outside phase 3.
- That the command and clamp are frozen under the current-sense flag.
- That the handover pulse lasts one cycle and happens only on entry from phase 3.
- That the held values are stable after handover, and that a bus drop returns the block to idle.
- That the clamp ramp and the frequency ramp of phase 3 end together.

Only the bench's scenarios can show the exact interpolated values at each step, the segment boundaries, and the ordering and capture of the endpoints. The same holds for the early balance freezing the current value, and for balance being ignored in the first two phases.

// File: rtl/hbss_pkg.sv
package hbss_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_ONE    = 3'd1,
    PH_TWO    = 3'd2,
    PH_THREE  = 3'd3,
    PH_HANDED = 3'd4
  } ss_phase_e;

  localparam int NSEG = 3;

endpackage

// File: rtl/hbss_seg_ramp.sv
// Exact linear ramp: after t advancing cycles off_o = floor(span*t/N).
module hbss_seg_ramp #(
  parameter int W = 11,
  parameter int N = 100
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         adv_i,
  input  logic [W-1:0] span_i,
  output logic [W-1:0] off_o,
  output logic         last_o
);
  localparam int TW = $clog2(N + 1);
  localparam int AW = TW + 1;

  function automatic logic [W-1:0] whole_step(input logic [W-1:0] d);
    return W'(32'(d) / 32'(N));
  endfunction

  function automatic logic [AW-1:0] frac_step(input logic [W-1:0] d);
    return AW'(32'(d) % 32'(N));
  endfunction

  logic [TW-1:0] t_q;
  logic [AW-1:0] acc_q;
  logic [W-1:0]  off_q;
  logic [AW-1:0] acc_sum;
  logic          wrap_w;

  assign acc_sum = acc_q + frac_step(span_i);
  assign wrap_w  = (acc_sum >= AW'(N));
  assign last_o  = (t_q == TW'(N - 1));
  assign off_o   = off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q   <= '0;
      acc_q <= '0;
      off_q <= '0;
    end else if (clr_i) begin
      t_q   <= '0;
      acc_q <= '0;
      off_q <= '0;
    end else if (adv_i && (t_q != TW'(N))) begin
      t_q   <= t_q + 1'b1;
      acc_q <= wrap_w ? (acc_sum - AW'(N)) : acc_sum;
      off_q <= off_q + whole_step(span_i) + W'(wrap_w);
    end
  end

endmodule

// File: rtl/hbss_limits.sv
// Captures the four sweep endpoints, forcing a non-increasing order.
module hbss_limits #(
  parameter int W   = 11,
  parameter int CAP = 1300
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] p0_o,
  output logic [W-1:0] p1_o,
  output logic [W-1:0] p2_o,
  output logic [W-1:0] p3_o,
  output logic [W-1:0] span0_o,
  output logic [W-1:0] span1_o,
  output logic [W-1:0] span2_o
);
  function automatic logic [W-1:0] lim(input logic [W-1:0] v, input logic [W-1:0] ceil);
    return (v > ceil) ? ceil : v;
  endfunction

  logic [W-1:0] c0, c1, c2, c3;

  always_comb begin
    c0 = lim(a_i, W'(CAP));
    c1 = lim(b_i, c0);
    c2 = lim(c_i, c1);
    c3 = lim(d_i, c2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p0_o <= '0;
      p1_o <= '0;
      p2_o <= '0;
      p3_o <= '0;
    end else if (load_i) begin
      p0_o <= c0;
      p1_o <= c1;
      p2_o <= c2;
      p3_o <= c3;
    end
  end

  assign span0_o = p0_o - p1_o;
  assign span1_o = p1_o - p2_o;
  assign span2_o = p2_o - p3_o;

endmodule

// File: rtl/hbss_fsm.sv
// Phase sequencing, freeze gating and handover events.
module hbss_fsm
  import hbss_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_ok_i,
  input  logic            cs_over_i,
  input  logic            fb_bal_i,
  input  logic [NSEG-1:0] last_i,
  output ss_phase_e       phase_o,
  output logic            ho_o,
  output logic            start_ev_o,
  output logic            early_ev_o,
  output logic            full_ev_o,
  output logic [NSEG-1:0] adv_o,
  output logic [NSEG-1:0] clr_o
);
  ss_phase_e phase_q, phase_d;
  logic      ho_q;
  logic      active_w, seg_last_w, adv_en_w;

  always_comb begin
    active_w = (phase_q == PH_ONE) || (phase_q == PH_TWO) || (phase_q == PH_THREE);
    case (phase_q)
      PH_ONE:   seg_last_w = last_i[0];
      PH_TWO:   seg_last_w = last_i[1];
      PH_THREE: seg_last_w = last_i[2];
      default:  seg_last_w = 1'b0;
    endcase
    start_ev_o = (phase_q == PH_IDLE) && bus_ok_i;
    early_ev_o = (phase_q == PH_THREE) && bus_ok_i && fb_bal_i;
    adv_en_w   = active_w && bus_ok_i && !cs_over_i && !early_ev_o;
    full_ev_o  = adv_en_w && (phase_q == PH_THREE) && seg_last_w;
    for (int g = 0; g < NSEG; g++) begin
      adv_o[g] = adv_en_w && (phase_q == ss_phase_e'(3'(g + 1)));
      clr_o[g] = (phase_q != ss_phase_e'(3'(g + 1)));
    end
  end

  always_comb begin
    phase_d = phase_q;
    if (!bus_ok_i) begin
      phase_d = PH_IDLE;
    end else begin
      case (phase_q)
        PH_IDLE:  phase_d = PH_ONE;
        PH_ONE:   if (adv_en_w && seg_last_w) phase_d = PH_TWO;
        PH_TWO:   if (adv_en_w && seg_last_w) phase_d = PH_THREE;
        PH_THREE: if (early_ev_o || full_ev_o) phase_d = PH_HANDED;
        default:  phase_d = phase_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      ho_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      ho_q    <= early_ev_o || full_ev_o;
    end
  end

  assign phase_o = phase_q;
  assign ho_o    = ho_q;

endmodule

// File: rtl/hb_softstart_seq.sv
module hb_softstart_seq
  import hbss_pkg::*;
#(
  parameter int FW      = 11,
  parameter int CW      = 8,
  parameter int FCAP    = 1300,
  parameter int CL_LO   = 75,
  parameter int CL_HI   = 225,
  parameter int PH1_LEN = 124800,
  parameter int PH2_LEN = 500000,
  parameter int PH3_LEN = 750000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_ok_i,
  input  logic          cs_over_i,
  input  logic          fb_bal_i,
  input  logic [FW-1:0] f_start_i,
  input  logic [FW-1:0] f_mid_i,
  input  logic [FW-1:0] f_max_i,
  input  logic [FW-1:0] f_min_i,
  output logic [FW-1:0] freq_o,
  output logic [CW-1:0] clamp_o,
  output logic [2:0]    phase_o,
  output logic          handover_o
);
  localparam int SEG_LEN [NSEG] = '{PH1_LEN, PH2_LEN, PH3_LEN};
  localparam logic [CW-1:0] CSPAN = CW'(CL_HI - CL_LO);

  ss_phase_e       phase_w;
  logic            start_ev_w, early_ev_w, full_ev_w;
  logic [NSEG-1:0] adv_w, clr_w, last_w;
  logic [FW-1:0]   span_w [NSEG];
  logic [FW-1:0]   off_w  [NSEG];
  logic [FW-1:0]   pt0_w, pt1_w, pt2_w, pt3_w;
  logic [CW-1:0]   coff_w;
  logic            clamp_last_w;
  logic [FW-1:0]   cur_freq_w, hold_f_q;
  logic [CW-1:0]   cur_clamp_w, hold_c_q;

  hbss_limits #(.W(FW), .CAP(FCAP)) u_limits (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (start_ev_w),
    .a_i     (f_start_i),
    .b_i     (f_mid_i),
    .c_i     (f_max_i),
    .d_i     (f_min_i),
    .p0_o    (pt0_w),
    .p1_o    (pt1_w),
    .p2_o    (pt2_w),
    .p3_o    (pt3_w),
    .span0_o (span_w[0]),
    .span1_o (span_w[1]),
    .span2_o (span_w[2])
  );

  hbss_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_ok_i   (bus_ok_i),
    .cs_over_i  (cs_over_i),
    .fb_bal_i   (fb_bal_i),
    .last_i     (last_w),
    .phase_o    (phase_w),
    .ho_o       (handover_o),
    .start_ev_o (start_ev_w),
    .early_ev_o (early_ev_w),
    .full_ev_o  (full_ev_w),
    .adv_o      (adv_w),
    .clr_o      (clr_w)
  );

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    hbss_seg_ramp #(.W(FW), .N(SEG_LEN[g])) u_ramp (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (clr_w[g]),
      .adv_i  (adv_w[g]),
      .span_i (span_w[g]),
      .off_o  (off_w[g]),
      .last_o (last_w[g])
    );
  end

  hbss_seg_ramp #(.W(CW), .N(PH3_LEN)) u_clamp_ramp (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (clr_w[2]),
    .adv_i  (adv_w[2]),
    .span_i (CSPAN),
    .off_o  (coff_w),
    .last_o (clamp_last_w)
  );

  always_comb begin
    case (phase_w)
      PH_ONE:    cur_freq_w = pt0_w - off_w[0];
      PH_TWO:    cur_freq_w = pt1_w - off_w[1];
      PH_THREE:  cur_freq_w = pt2_w - off_w[2];
      PH_HANDED: cur_freq_w = hold_f_q;
      default:   cur_freq_w = '0;
    endcase
    case (phase_w)
      PH_THREE:  cur_clamp_w = CW'(CL_LO) + coff_w;
      PH_HANDED: cur_clamp_w = hold_c_q;
      default:   cur_clamp_w = CW'(CL_LO);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_f_q <= '0;
      hold_c_q <= CW'(CL_LO);
    end else if (early_ev_w) begin
      hold_f_q <= cur_freq_w;
      hold_c_q <= cur_clamp_w;
    end else if (full_ev_w) begin
      hold_f_q <= pt3_w;
      hold_c_q <= CW'(CL_HI);
    end
  end

  assign freq_o  = cur_freq_w;
  assign clamp_o = cur_clamp_w;
  assign phase_o = phase_w;

endmodule

// File: rtl/hbss_chk.sv
module hbss_chk #(
  parameter int FW    = 11,
  parameter int CW    = 8,
  parameter int FCAP  = 1300,
  parameter int CL_LO = 75
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_ok_i,
  input logic          cs_over_i,
  input logic          fb_bal_i,
  input logic [FW-1:0] freq_o,
  input logic [CW-1:0] clamp_o,
  input logic [2:0]    phase_o,
  input logic          handover_o,
  input logic          seg_last,
  input logic          clamp_last
);
  logic active;
  assign active = (phase_o >= 3'd1) && (phase_o <= 3'd3);

  a_r1_idle_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 3'd0) |-> (freq_o == '0) && (clamp_o == CW'(CL_LO)) && !handover_o);

  a_r2_start_cap: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (freq_o <= FW'(FCAP)));

  a_r3_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (active && (phase_o == $past(phase_o))) |-> (freq_o <= $past(freq_o)));

  a_r5_clamp_low: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o < 3'd3) |-> (clamp_o == CW'(CL_LO)));

  a_r5_ramps_end_together: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 3'd3) |-> (seg_last == clamp_last));

  a_r6_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_over_i && active && bus_ok_i) |=> ($stable(freq_o) && $stable(clamp_o)));

  a_r7_balance_hands_over: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_o == 3'd3) && bus_ok_i && fb_bal_i) |=> (phase_o == 3'd4) && handover_o);

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    handover_o |=> !handover_o);

  a_r8_pulse_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
    handover_o |-> (phase_o == 3'd4) && ($past(phase_o) == 3'd3));

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_o == 3'd4) && ($past(phase_o) == 3'd4)) |-> ($stable(freq_o) && $stable(clamp_o)));

  a_r9_abort: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ok_i |=> (phase_o == 3'd0));

endmodule

bind hb_softstart_seq hbss_chk #(
  .FW(FW), .CW(CW), .FCAP(FCAP), .CL_LO(CL_LO)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_ok_i   (bus_ok_i),
  .cs_over_i  (cs_over_i),
  .fb_bal_i   (fb_bal_i),
  .freq_o     (freq_o),
  .clamp_o    (clamp_o),
  .phase_o    (phase_o),
  .handover_o (handover_o),
  .seg_last   (last_w[2]),
  .clamp_last (clamp_last_w)
);

// File: tb/hb_softstart_seq_tb.sv
`timescale 1ns/1ps
module hb_softstart_seq_tb;
  localparam int FW = 11, CW = 8;
  localparam int N1 = 40, N2 = 70, N3 = 100;
  localparam int CAP = 1300, CLO = 75, CHI = 225;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, bus_ok, cs_over, fb_bal;
  logic [FW-1:0] f_start, f_mid, f_max, f_min;
  logic [FW-1:0] freq;
  logic [CW-1:0] clamp;
  logic [2:0]    phase;
  logic          ho;

  hb_softstart_seq #(
    .FW(FW), .CW(CW), .FCAP(CAP), .CL_LO(CLO), .CL_HI(CHI),
    .PH1_LEN(N1), .PH2_LEN(N2), .PH3_LEN(N3)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_ok_i(bus_ok), .cs_over_i(cs_over), .fb_bal_i(fb_bal),
    .f_start_i(f_start), .f_mid_i(f_mid), .f_max_i(f_max), .f_min_i(f_min),
    .freq_o(freq), .clamp_o(clamp), .phase_o(phase), .handover_o(ho)
  );

  int errs = 0, checks = 0;
  string scen = "";
  bit fin = 0;

  // behavioural reference state
  int m_ph = 0, m_t = 0, m_ho = 0, m_hf = 0, m_hc = CLO;
  int m_s, m_m, m_x, m_n;

  function automatic int minv(int a, int b);
    return (a < b) ? a : b;
  endfunction

  function automatic int exp_freq();
    case (m_ph)
      1: return m_s - ((m_s - m_m) * m_t) / N1;
      2: return m_m - ((m_m - m_x) * m_t) / N2;
      3: return m_x - ((m_x - m_n) * m_t) / N3;
      4: return m_hf;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_clamp();
    case (m_ph)
      3: return CLO + ((CHI - CLO) * m_t) / N3;
      4: return m_hc;
      default: return CLO;
    endcase
  endfunction

  function automatic int seg_len(int p);
    return (p == 1) ? N1 : ((p == 2) ? N2 : N3);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_t = 0; m_ho = 0; m_hf = 0; m_hc = CLO;
    end else begin
      m_ho = 0;
      if (m_ph != 0 && !bus_ok) begin
        m_ph = 0;
      end else if (m_ph == 0) begin
        if (bus_ok) begin
          m_s = minv(int'(f_start), CAP);
          m_m = minv(int'(f_mid), m_s);
          m_x = minv(int'(f_max), m_m);
          m_n = minv(int'(f_min), m_x);
          m_ph = 1; m_t = 0;
        end
      end else if (m_ph == 3 && fb_bal) begin
        m_hf = exp_freq(); m_hc = exp_clamp(); m_ph = 4; m_ho = 1;
      end else if (m_ph >= 1 && m_ph <= 3 && !cs_over) begin
        m_t++;
        if (m_t == seg_len(m_ph)) begin
          if (m_ph == 3) begin
            m_hf = m_n; m_hc = CHI; m_ph = 4; m_ho = 1;
          end else begin
            m_ph++; m_t = 0;
          end
        end
      end
    end
  end

  task automatic chk(string tag, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errs++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  function automatic string tagf();
    if (scen != "") return scen;
    case (m_ph)
      0: return "R1";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      default: return "R8";
    endcase
  endfunction

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !fin) begin
      chk(tagf(), "freq", int'(freq), exp_freq());
      chk(tagf(), "clamp", int'(clamp), exp_clamp());
      chk(tagf(), "phase", int'(phase), m_ph);
      chk(tagf(), "handover", int'(ho), m_ho);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_f(int a, int b, int c, int d);
    f_start = FW'(a); f_mid = FW'(b); f_max = FW'(c); f_min = FW'(d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int rec_f, rec_c, hcnt;
    rst_n = 1'b0; bus_ok = 1'b0; cs_over = 1'b0; fb_bal = 1'b0;
    set_f(1000, 600, 300, 100);
    cyc(4);
    rst_n = 1'b1;
    cyc(1);
    chk("R1", "reset phase", int'(phase), 0);
    chk("R1", "reset freq", int'(freq), 0);
    chk("R1", "reset clamp", int'(clamp), CLO);
    chk("R1", "reset handover", int'(ho), 0);

    // full sweep, no freeze, no balance
    bus_ok = 1'b1;
    cyc(1);
    chk("R2", "start phase", int'(phase), 1);
    chk("R2", "start freq", int'(freq), 1000);
    cyc(N1);
    chk("R3", "phase1 end", int'(phase), 2);
    chk("R3", "phase1 end freq", int'(freq), 600);
    cyc(N2);
    chk("R4", "phase2 end", int'(phase), 3);
    chk("R4", "phase2 end freq", int'(freq), 300);
    chk("R5", "clamp at phase3 entry", int'(clamp), CLO);
    cyc(50);
    chk("R5", "mid phase3 freq", int'(freq), 200);
    chk("R5", "mid phase3 clamp", int'(clamp), 150);
    hcnt = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (ho) hcnt++;
    end
    chk("R8", "pulse count", hcnt, 1);
    chk("R8", "final freq", int'(freq), 100);
    chk("R8", "final clamp", int'(clamp), CHI);
    chk("R8", "final phase", int'(phase), 4);
    set_f(1200, 600, 300, 50);
    cyc(5);
    chk("R10", "inputs ignored after capture", int'(freq), 100);
    bus_ok = 1'b0;
    cyc(1);
    chk("R9", "drop to idle", int'(phase), 0);
    chk("R9", "idle freq", int'(freq), 0);

    // freeze scenario
    scen = "R6";
    set_f(900, 500, 250, 120);
    bus_ok = 1'b1;
    cyc(10);
    cs_over = 1'b1; rec_f = int'(freq);
    cyc(6);
    chk("R6", "frozen phase1 freq", int'(freq), rec_f);
    cs_over = 1'b0;
    cyc(60);
    cs_over = 1'b1; rec_f = int'(freq);
    cyc(5);
    chk("R6", "frozen phase2 freq", int'(freq), rec_f);
    cs_over = 1'b0;
    cyc(80);
    cs_over = 1'b1; rec_f = int'(freq); rec_c = int'(clamp);
    cyc(4);
    chk("R6", "frozen phase3 freq", int'(freq), rec_f);
    chk("R6", "frozen phase3 clamp", int'(clamp), rec_c);
    cs_over = 1'b0;
    cyc(120);
    chk("R6", "completion after freezes", int'(phase), 4);
    bus_ok = 1'b0;
    cyc(2);

    // balance: ignored early, honoured in phase 3
    scen = "R7";
    set_f(1000, 600, 300, 100);
    fb_bal = 1'b1; bus_ok = 1'b1;
    cyc(20);
    chk("R7", "balance ignored in phase1", int'(phase), 1);
    fb_bal = 1'b0;
    cyc(N1 + N2 + 5);
    chk("R7", "in phase3", int'(phase), 3);
    rec_f = int'(freq); rec_c = int'(clamp);
    fb_bal = 1'b1;
    cyc(1);
    fb_bal = 1'b0;
    chk("R7", "early handover phase", int'(phase), 4);
    chk("R7", "early handover pulse", int'(ho), 1);
    chk("R7", "held freq", int'(freq), rec_f);
    chk("R7", "held clamp", int'(clamp), rec_c);
    cyc(1);
    chk("R7", "pulse ends", int'(ho), 0);
    bus_ok = 1'b0;
    cyc(2);

    // cap and ordering, then abort in phase 3
    scen = "R10";
    set_f(2000, 1500, 1400, 200);
    bus_ok = 1'b1;
    cyc(1);
    chk("R2", "capped start", int'(freq), 1300);
    cyc(N1);
    chk("R10", "mid limited to start", int'(freq), 1300);
    cyc(N2);
    chk("R10", "max limited to mid", int'(freq), 1300);
    cyc(20);
    bus_ok = 1'b0;
    cyc(1);
    chk("R9", "abort phase", int'(phase), 0);
    chk("R9", "abort no pulse", int'(ho), 0);
    cyc(3);

    fin = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule